// File: doc/BRIEF.md
# Two-Point Gaussian RMS Jitter Estimator

This unit is the arithmetic back end of an on-chip period-jitter test. A separate front end compares a clock against two delayed copies of itself and counts how often the clock edge leads each copy. It also times a ring oscillator built around each of the two delay settings. This unit takes those integer results and returns an estimate of the jitter's standard deviation. It assumes the jitter is Gaussian and uses the two measured lead probabilities as two points on its cumulative distribution.

A one-cycle `start` captures the inputs. The unit forms the delay difference from the two oscillator periods and quantizes each lead probability to 1/1024. It maps each probability to a standard-normal abscissa through an internal inverse-CDF table that holds only its lower half. It then divides the delay difference by the abscissa difference. All three divisions share one restoring divider that produces one quotient bit per clock. The result is an unsigned value with 8 fractional bits, in the units of the oscillator period inputs. A one-cycle `done` marks a new result.

Top module: `jit_rms_est`

## Requirements
- R1: The delay difference is `osc_per_a - osc_per_b`, taken as a signed value. Only this difference enters the result.
- R2: Each probability index is `q = floor(lead * 1024 / cmp_total)`, computed with `lead_cnt_a` for the first setting and `lead_cnt_b` for the second. Any index above 1024 is limited to 1024.
- R3: An index q in 1..1023 maps to the standard-normal abscissa x where the CDF equals q/1024. The abscissa is signed with 8 fractional bits and is accurate to within one LSB.
- R4: The abscissa is odd-symmetric about index 512, so x(1024-q) = -x(q) and x(512) = 0. Exchanging the two settings' lead counts and also their periods therefore gives an identical result.
- R5: Index 0 is treated as index 1, and index 1024 as index 1023. `sat` is 1 for a result in which either index was clamped this way, and 0 otherwise.
- R6: When neither error condition holds, `sigma_q8 = floor(|d| * 65536 / |x1 - x2|)`. Here d is the delay difference and x1, x2 are the abscissas in LSBs.
- R7: `err` is 1 and `sigma_q8` is 0 when x1 equals x2, when d is 0, or when d and x1 - x2 have opposite signs. No final division is run in that case.
- R8: `done` is a one-cycle pulse. With the default divider width of 32 it comes exactly 103 cycles after the clock edge that accepts `start`, or 69 cycles after it on the error path. `busy` is high from that accepting edge until `done`.
- R9: `start` while `busy` is high has no effect, and the inputs applied with it are not used.
- R10: After reset `busy`, `done`, `sigma_q8`, `sat` and `err` are all 0. The result outputs keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept inputs and begin an estimate when idle |
| lead_cnt_a | input | 16 | Lead count for the shorter delay setting |
| lead_cnt_b | input | 16 | Lead count for the longer delay setting |
| cmp_total | input | 16 | Comparisons made per setting (typically 1000) |
| osc_per_a | input | 16 | Ring-oscillator period with the first setting |
| osc_per_b | input | 16 | Ring-oscillator period with the second setting |
| busy | output | 1 | An estimate is in progress |
| done | output | 1 | One-cycle pulse: a new result is on the outputs |
| sigma_q8 | output | 32 | RMS jitter estimate, 8 fractional bits |
| sat | output | 1 | A probability index was clamped at the end of the table |
| err | output | 1 | Degenerate or inconsistent inputs, no estimate |

## Verification
The bench targets several corner cases. Lead counts of 0 and of more than `cmp_total` probe the table ends: a design that skipped the clamp would read an undefined entry or wrap its index, and would not raise `sat`. An exactly symmetric pair, and the same pair with the settings exchanged, exposes any error in the mirrored upper half, because the two results would differ. Equal lead counts, a zero delay difference, and a delay difference of the wrong sign must each take the short error path; a design that divided anyway would return a finite value or hang on a zero divisor. A second `start` during a run carries different inputs, and a design that accepted it would restart, miss its `done` cycle, or report the wrong sigma.

// File: rtl/jit_pkg.sv
package jit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROB_A,
        ST_PROB_B,
        ST_MAP,
        ST_SIGMA
    } est_state_e;

    // natural logarithm for elaboration-time table build
    function automatic real ln_r(real v);
        real m;
        real y;
        real y2;
        real s;
        real term;
        int  k;
        m = v;
        k = 0;
        while (m < 1.0) begin
            m = m * 2.0;
            k = k - 1;
        end
        while (m >= 2.0) begin
            m = m / 2.0;
            k = k + 1;
        end
        y    = (m - 1.0) / (m + 1.0);
        y2   = y * y;
        s    = 0.0;
        term = y;
        for (int i = 0; i < 40; i++) begin
            s    = s + term / real'(2 * i + 1);
            term = term * y2;
        end
        return 2.0 * s + real'(k) * 0.6931471805599453;
    endfunction

    function automatic real sqrt_r(real v);
        real r;
        r = (v > 1.0) ? v : 1.0;
        for (int i = 0; i < 60; i++) begin
            r = 0.5 * (r + v / r);
        end
        return r;
    endfunction

    // magnitude of the lower-tail inverse normal at idx / 2**qb, scaled by 2**fb
    function automatic int icdf_mag(int idx, int qb, int fb);
        real p;
        real t;
        real m;
        int  k;
        k = (idx < 1) ? 1 : idx;
        if (2 * k >= (1 << qb)) begin
            return 0;
        end
        p = real'(k) / real'(1 << qb);
        t = sqrt_r(-2.0 * ln_r(p));
        m = t - (2.515517 + 0.802853 * t + 0.010328 * t * t) /
                (1.0 + 1.432788 * t + 0.189269 * t * t + 0.001308 * t * t * t);
        return int'(m * real'(1 << fb));
    endfunction

endpackage

// File: rtl/jit_div.sv
module jit_div #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [DW-1:0] quo,
    output logic          rdy
);
    localparam int CNT_W = $clog2(DW + 1);

    logic [DW-1:0]    dvd_q;
    logic [DW-1:0]    rem_q;
    logic [DW-1:0]    den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rdy_q;
    logic [DW:0]      trial;

    always_comb trial = {rem_q, dvd_q[DW-1]} - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (go) begin
                dvd_q <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNT_W'(DW);
            end else if (cnt_q != '0) begin
                if (!trial[DW]) begin
                    rem_q <= trial[DW-1:0];
                    dvd_q <= {dvd_q[DW-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[DW-2:0], dvd_q[DW-1]};
                    dvd_q <= {dvd_q[DW-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
            end
        end
    end

    assign quo = dvd_q;
    assign rdy = rdy_q;

    // R8
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst) rdy_q |=> !rdy_q);
    // R6
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rdy_q && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/jit_icdf.sv
module jit_icdf #(
    parameter int QB = 10,
    parameter int FB = 8,
    parameter int XW = 12
) (
    input  logic [QB:0]          idx,
    output logic signed [XW-1:0] x,
    output logic                 clamped
);
    localparam int FULL = 1 << QB;
    localparam int HALF = 1 << (QB - 1);

    logic [XW-1:0] mag_tbl [0:HALF];

    for (genvar g = 0; g <= HALF; g++) begin : g_tbl
        localparam int MAG = jit_pkg::icdf_mag(g, QB, FB);
        assign mag_tbl[g] = XW'(MAG);
    end

    logic [QB:0] ci;

    always_comb begin
        clamped = (idx == '0) || (idx >= (QB+1)'(FULL));
        if (idx == '0)                     ci = (QB+1)'(1);
        else if (idx >= (QB+1)'(FULL))     ci = (QB+1)'(FULL - 1);
        else                               ci = idx;
        if (ci <= (QB+1)'(HALF)) x = -$signed(mag_tbl[ci[QB-1:0]]);
        else                     x =  $signed(mag_tbl[(QB+1)'(FULL) - ci]);
    end
endmodule

// File: rtl/jit_rms_est.sv
module jit_rms_est #(
    parameter int CW = 16,
    parameter int PW = 16,
    parameter int QB = 10,
    parameter int FB = 8,
    parameter int XW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] lead_cnt_a,
    input  logic [CW-1:0] lead_cnt_b,
    input  logic [CW-1:0] cmp_total,
    input  logic [PW-1:0] osc_per_a,
    input  logic [PW-1:0] osc_per_b,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] sigma_q8,
    output logic          sat,
    output logic          err
);
    import jit_pkg::*;

    localparam int FULL = 1 << QB;

    est_state_e    st_q;
    logic [CW-1:0] lead_b_q;
    logic [PW-1:0] per_a_q, per_b_q;
    logic [QB:0]   qa_q, qb_q;
    logic [DW-1:0] num_q, den_q;
    logic          go_q;
    logic          done_q, sat_q, err_q, sat_pend_q;
    logic [DW-1:0] sigma_q;

    logic [DW-1:0] dv_quo;
    logic          dv_rdy;

    jit_div #(.DW(DW)) i_div (
        .clk(clk), .rst(rst), .go(go_q), .num(num_q), .den(den_q),
        .quo(dv_quo), .rdy(dv_rdy)
    );

    logic signed [XW-1:0] xa, xb;
    logic                 clamp_a, clamp_b;

    jit_icdf #(.QB(QB), .FB(FB), .XW(XW)) i_icdf_a (.idx(qa_q), .x(xa), .clamped(clamp_a));
    jit_icdf #(.QB(QB), .FB(FB), .XW(XW)) i_icdf_b (.idx(qb_q), .x(xb), .clamped(clamp_b));

    logic [QB:0]          q_lim;
    logic signed [PW:0]   dd;
    logic signed [XW:0]   dx;
    logic [PW:0]          dd_mag;
    logic [XW:0]          dx_mag;
    logic                 bad;

    always_comb begin
        q_lim  = (dv_quo > DW'(FULL)) ? (QB+1)'(FULL) : dv_quo[QB:0];
        dd     = $signed({1'b0, per_a_q}) - $signed({1'b0, per_b_q});
        dx     = (XW+1)'(xa) - (XW+1)'(xb);
        dd_mag = dd[PW] ? (PW+1)'(-dd) : (PW+1)'(dd);
        dx_mag = dx[XW] ? (XW+1)'(-dx) : (XW+1)'(dx);
        bad    = (dx == '0) || (dd == '0) || (dd[PW] != dx[XW]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            lead_b_q   <= '0;
            per_a_q    <= '0;
            per_b_q    <= '0;
            qa_q       <= '0;
            qb_q       <= '0;
            num_q      <= '0;
            den_q      <= '0;
            go_q       <= 1'b0;
            done_q     <= 1'b0;
            sat_q      <= 1'b0;
            err_q      <= 1'b0;
            sat_pend_q <= 1'b0;
            sigma_q    <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    lead_b_q <= lead_cnt_b;
                    per_a_q  <= osc_per_a;
                    per_b_q  <= osc_per_b;
                    num_q    <= DW'(lead_cnt_a) << QB;
                    den_q    <= DW'(cmp_total);
                    go_q     <= 1'b1;
                    st_q     <= ST_PROB_A;
                end
                ST_PROB_A: if (dv_rdy) begin
                    qa_q  <= q_lim;
                    num_q <= DW'(lead_b_q) << QB;
                    go_q  <= 1'b1;
                    st_q  <= ST_PROB_B;
                end
                ST_PROB_B: if (dv_rdy) begin
                    qb_q <= q_lim;
                    st_q <= ST_MAP;
                end
                ST_MAP: begin
                    if (bad) begin
                        sat_q   <= clamp_a | clamp_b;
                        err_q   <= 1'b1;
                        sigma_q <= '0;
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                    end else begin
                        sat_pend_q <= clamp_a | clamp_b;
                        num_q      <= DW'(dd_mag) << (2 * FB);
                        den_q      <= DW'(dx_mag);
                        go_q       <= 1'b1;
                        st_q       <= ST_SIGMA;
                    end
                end
                ST_SIGMA: if (dv_rdy) begin
                    sigma_q <= dv_quo;
                    sat_q   <= sat_pend_q;
                    err_q   <= 1'b0;
                    done_q  <= 1'b1;
                    st_q    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign sigma_q8 = sigma_q;
    assign sat      = sat_q;
    assign err      = err_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);
    // R9
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (rst) (done_q && err_q) |-> (sigma_q == '0));
    // R3
    icdf_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MAP && qa_q < qb_q) |-> (xa <= xb));
    // R4
    icdf_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MAP && qa_q == (QB+1)'(FULL / 2)) |-> (xa == '0));
endmodule

// File: tb/test_jit_rms_est.sv
module test_jit_rms_est;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   lead_cnt_a = '0, lead_cnt_b = '0, cmp_total = 16'd1000;
    logic [15:0]   osc_per_a = '0, osc_per_b = '0;
    logic          busy, done, sat, err;
    logic [DW-1:0] sigma_q8;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int left = 0;
    int exp_lat = 0;
    bit exp_done = 1'b0;

    always #2 clk = ~clk;

    jit_rms_est i_jit_rms_est (
        .clk(clk), .rst(rst), .start(start),
        .lead_cnt_a(lead_cnt_a), .lead_cnt_b(lead_cnt_b), .cmp_total(cmp_total),
        .osc_per_a(osc_per_a), .osc_per_b(osc_per_b),
        .busy(busy), .done(done), .sigma_q8(sigma_q8), .sat(sat), .err(err)
    );

    // cycle-level reference of busy/done (R8, R9)
    always @(posedge clk) begin
        if (rst) begin
            left     <= 0;
            exp_done <= 1'b0;
        end else begin
            exp_done <= 1'b0;
            if (left == 0 && start) left <= exp_lat;
            else if (left > 0) begin
                left <= left - 1;
                if (left == 1) exp_done <= 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            tests++;
            if (done !== exp_done || busy !== (left > 0)) begin
                fails++;
                $display("FAIL R8: done/busy got %0b/%0b expected %0b/%0b", done, busy, exp_done, left > 0);
            end
        end
    end

    function automatic int xq(int q);
        real p;
        real t;
        real m;
        int  k;
        k = (q < 1) ? 1 : ((q > 1023) ? 1023 : q);
        if (k == 512) return 0;
        p = (k < 512) ? real'(k) / 1024.0 : real'(1024 - k) / 1024.0;
        t = $sqrt(-2.0 * $ln(p));
        m = t - (2.515517 + 0.802853 * t + 0.010328 * t * t) /
                (1.0 + 1.432788 * t + 0.189269 * t * t + 0.001308 * t * t * t);
        return (k < 512) ? -int'(m * 256.0) : int'(m * 256.0);
    endfunction

    task automatic check(string tag, longint got, longint expv);
        tests++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    task automatic check_rng(string tag, longint got, longint lo, longint hi);
        tests++;
        if (got < lo || got > hi) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    task automatic run_case(string tag, int na, int nb, int tot, int pa, int pb,
                            bit intrude, output longint res);
        int qa, qb, xa, xb, dd, dx, adx;
        bit e, s;
        longint m;
        qa = (na * 1024) / tot; if (qa > 1024) qa = 1024;
        qb = (nb * 1024) / tot; if (qb > 1024) qb = 1024;
        s  = (qa == 0) || (qa >= 1024) || (qb == 0) || (qb >= 1024);
        xa = xq(qa);
        xb = xq(qb);
        dd = pa - pb;
        dx = xa - xb;
        e  = (dx == 0) || (dd == 0) || ((dd < 0) != (dx < 0));
        exp_lat = e ? 2 * DW + 5 : 3 * DW + 7;
        @(negedge clk);
        lead_cnt_a = 16'(na); lead_cnt_b = 16'(nb); cmp_total = 16'(tot);
        osc_per_a = 16'(pa); osc_per_b = 16'(pb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (10) @(negedge clk);
            lead_cnt_a = 16'd500; lead_cnt_b = 16'd500; osc_per_a = 16'd10; osc_per_b = 16'd900;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (exp_lat + 4) @(negedge clk);
        check({tag, " err R7"}, err, e);
        check({tag, " sat R5"}, sat, s);
        if (e) begin
            check({tag, " sigma R7"}, sigma_q8, 0);
        end else begin
            adx = (dx < 0) ? -dx : dx;
            m = longint'((dd < 0) ? -dd : dd) * 65536;
            check_rng({tag, " sigma R6"}, sigma_q8, m / (adx + 2), m / ((adx > 2) ? adx - 2 : 1));
        end
        res = sigma_q8;
    endtask

    initial begin
        longint r1, r2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("reset busy R10", busy, 0);
        check("reset done R10", done, 0);
        check("reset sigma R10", sigma_q8, 0);
        check("reset flags R10", {sat, err}, 0);
        // R1 R2 R3 R6: typical case, both delays sides of the period
        run_case("nominal", 154, 813, 1000, 1152, 1230, 1'b0, r1);
        check("hold R10", sigma_q8, r1);
        // R4: symmetric pair and exchanged settings
        run_case("sym", 256, 768, 1024, 1000, 1100, 1'b0, r1);
        run_case("sym swap", 768, 256, 1024, 1100, 1000, 1'b0, r2);
        check("swap equal R4", r2, r1);
        // opposite ordering, still consistent
        run_case("reversed", 800, 150, 1000, 1250, 1170, 1'b0, r1);
        // R5: zero and full counts
        run_case("ends", 0, 1000, 1000, 1100, 1200, 1'b0, r1);
        // R5 R2: count above total
        run_case("over", 300, 1200, 1000, 1100, 1190, 1'b0, r1);
        // R7: equal abscissas, zero delay, wrong sign
        run_case("equal x", 500, 500, 1000, 1100, 1200, 1'b0, r1);
        run_case("zero d", 200, 800, 1000, 1150, 1150, 1'b0, r1);
        run_case("bad sign", 200, 800, 1000, 1300, 1200, 1'b0, r1);
        // R9: second start during run is ignored
        run_case("intrude R9", 180, 820, 1000, 1140, 1225, 1'b1, r1);
        // R1: absolute offset does not matter
        run_case("offset a", 180, 820, 1000, 1140, 1225, 1'b0, r1);
        run_case("offset b", 180, 820, 1000, 5140, 5225, 1'b0, r2);
        check("offset R1", r2, r1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule